// File: doc/BRIEF.md
# Instruction-Driven Static Crossbar Switch

This block is the routing switch of one tile in a mesh of compute tiles. It has five ports: four toward the neighbouring tiles (north, east, south, west) and one toward the local processor. Every port has a four-entry input queue and a four-entry output queue, each with a valid/ready handshake. Routing is not decoded from packet headers. A small switch program, held in a private instruction memory and stepped by the switch's own program counter, says in each cycle which input queue feeds which output queue.

An instruction gives a source choice for each of the five outputs. All of its route operations move together, or none of them move. If any named source queue is empty, or any named destination queue is full, the program counter holds and the same instruction tries again in the next cycle. A branch flag with a target address lets the program loop. An instruction that would take one source word twice, or that uses a code that does not exist, is skipped and reported on an error pulse.

The program is loaded through a write port while the switch is not running. The switch starts running on the first clock edge after reset is released and executes from address 0 on the edge after that. Port 4 is the processor's channel into and out of the network.

Top module: `tile_route_switch`

## Requirements
- R1: Port index p is 0 = north, 1 = east, 2 = south, 3 = west, 4 = processor. Bits [3p+2:3p] of an instruction select the source for output p. Code 0 means idle, and codes 1 to 5 select input port (code-1). A moved word appears unchanged at the selected output.
- R2: All route operations of one instruction move their words on the same clock edge, so every destination of the instruction gains its word in the same cycle.
- R3: An instruction issues only when every source it names is non-empty and every destination it names is not full. Otherwise no word moves and the same instruction is retried in the next cycle.
- R4: When an instruction completes, the program counter loads the target in bits [19:16] if bit 15 is set. Otherwise it increments and wraps from 15 to 0. An all-idle instruction completes at once.
- R5: An instruction in which two outputs select the same source, or any field holds code 6 or 7, moves no data. It still advances the program counter, and err_o is high for the one cycle after the edge that skipped it.
- R6: Each input queue holds 4 words, and in_ready_o of a port is low exactly when its queue is full. A word on a stalled output stays valid and unchanged until it is accepted.
- R7: There is no combinational path from input to output. A word accepted on edge k can be valid at an output no earlier than the cycle after edge k+1.
- R8: Program writes take effect only while the switch is not running, that is during reset and on the first edge after release. Writes made later are ignored. Execution starts at address 0.
- R9: Words from one input leave through the crossbar in the order they arrived, and each output presents its words in the order they were routed to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_we_i | input | 1 | Program memory write enable |
| prog_addr_i | input | AW | Program memory write address |
| prog_data_i | input | 16+AW | Instruction word to store |
| in_valid_i | input | 5 | Per-port input valid |
| in_data_i | input | 5*W | Per-port input words, port p at bits [p*W+W-1:p*W] |
| in_ready_o | output | 5 | Per-port input queue has space |
| out_valid_o | output | 5 | Per-port output word available |
| out_data_o | output | 5*W | Per-port output words, same packing as the input |
| out_ready_i | input | 5 | Per-port downstream accepts the word |
| err_o | output | 1 | One-cycle pulse after a malformed instruction is skipped |

## Verification
Input handshakes take effect on the edge where they are sampled, so in_ready_o reflects a queue fill one cycle later. A routed word reaches out_valid_o one cycle after the edge that issues its instruction, which makes two cycles from input acceptance at the earliest. err_o rises in the cycle after the edge that skips a bad instruction. The bench holds a queue-based reference model that is advanced on every rising edge from the same inputs. The outputs are compared with the model on the falling edge in between, so each result is sampled in the cycle it is due. The directed checks read the outputs on the falling edges that these latencies give, counted from the edge where the stimulus was taken.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int NPORT    = 5;
  localparam int SELW     = 3;
  localparam int FIELDS_W = NPORT * SELW;

  typedef enum logic [SELW-1:0] {
    SEL_IDLE = 3'd0,
    SEL_N    = 3'd1,
    SEL_E    = 3'd2,
    SEL_S    = 3'd3,
    SEL_W    = 3'd4,
    SEL_P    = 3'd5
  } sel_e;
endpackage

// File: rtl/tsw_fifo.sv
module tsw_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= step(wr_q);
      if (do_pop)  rd_q <= step(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/tsw_imem.sv
module tsw_imem #(
  parameter int IW = 20,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [IW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [IW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tsw_seq.sv
module tsw_seq
  import tsw_pkg::*;
#(
  parameter int AW = 4,
  parameter int IW = FIELDS_W + 1 + AW
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [IW-1:0]              instr_i,
  input  logic [NPORT-1:0]           src_avail_i,
  input  logic [NPORT-1:0]           dst_space_i,
  output logic [AW-1:0]              pc_o,
  output logic                       running_o,
  output logic [NPORT-1:0]           push_o,
  output logic [NPORT-1:0]           pop_o,
  output logic [NPORT-1:0][SELW-1:0] src_sel_o,
  output logic                       err_o
);
  logic [AW-1:0]    pc_q;
  logic             run_q, err_q;
  logic [NPORT-1:0] used, src_mask;
  logic             dup, bad, ready, fault, fire, advance;
  logic             br;
  logic [AW-1:0]    tgt;

  assign br  = instr_i[FIELDS_W];
  assign tgt = instr_i[FIELDS_W+1 +: AW];

  always_comb begin
    used      = '0;
    src_mask  = '0;
    dup       = 1'b0;
    bad       = 1'b0;
    ready     = 1'b1;
    src_sel_o = '0;
    for (int k = 0; k < NPORT; k++) begin
      logic [SELW-1:0] code;
      code = instr_i[k*SELW +: SELW];
      if (code != SEL_IDLE) begin
        used[k] = 1'b1;
        if (code > SEL_P) begin
          bad = 1'b1;
        end else begin
          src_sel_o[k] = code - 1'b1;
          if (src_mask[code - 1'b1]) dup = 1'b1;
          src_mask[code - 1'b1] = 1'b1;
          if (!src_avail_i[code - 1'b1] || !dst_space_i[k]) ready = 1'b0;
        end
      end
    end
  end

  assign fault   = run_q & (dup | bad);
  assign fire    = run_q & ~(dup | bad) & ready;
  assign advance = fault | fire;
  assign push_o  = fire ? used : '0;
  assign pop_o   = fire ? src_mask : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      run_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      err_q <= fault;
      if (advance) pc_q <= br ? tgt : pc_q + 1'b1;
    end
  end

  assign pc_o      = pc_q;
  assign running_o = run_q;
  assign err_o     = err_q;
endmodule

// File: rtl/tile_route_switch.sv
module tile_route_switch
  import tsw_pkg::*;
#(
  parameter int W      = 32,
  parameter int AW     = 4,
  parameter int FDEPTH = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  prog_we_i,
  input  logic [AW-1:0]         prog_addr_i,
  input  logic [FIELDS_W+AW:0]  prog_data_i,
  input  logic [NPORT-1:0]      in_valid_i,
  input  logic [NPORT*W-1:0]    in_data_i,
  output logic [NPORT-1:0]      in_ready_o,
  output logic [NPORT-1:0]      out_valid_o,
  output logic [NPORT*W-1:0]    out_data_o,
  input  logic [NPORT-1:0]      out_ready_i,
  output logic                  err_o
);
  localparam int IW = FIELDS_W + 1 + AW;

  logic [NPORT-1:0]           in_empty, in_full, out_empty, out_full;
  logic [NPORT-1:0]           xb_push, xb_pop;
  logic [NPORT-1:0][SELW-1:0] xb_sel;
  logic [W-1:0]               in_head  [NPORT];
  logic [W-1:0]               out_head [NPORT];
  logic [W-1:0]               xb_data  [NPORT];
  logic [AW-1:0]              pc;
  logic [IW-1:0]              instr;
  logic                       seq_running;

  tsw_imem #(.IW(IW), .AW(AW)) u_imem (
    .clk_i   (clk_i),
    .we_i    (prog_we_i & ~seq_running),
    .waddr_i (prog_addr_i),
    .wdata_i (prog_data_i),
    .raddr_i (pc),
    .rdata_o (instr)
  );

  tsw_seq #(.AW(AW), .IW(IW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .instr_i     (instr),
    .src_avail_i (~in_empty),
    .dst_space_i (~out_full),
    .pc_o        (pc),
    .running_o   (seq_running),
    .push_o      (xb_push),
    .pop_o       (xb_pop),
    .src_sel_o   (xb_sel),
    .err_o       (err_o)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    tsw_fifo #(.W(W), .DEPTH(FDEPTH)) u_in (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (in_valid_i[p]),
      .data_i  (in_data_i[p*W +: W]),
      .pop_i   (xb_pop[p]),
      .data_o  (in_head[p]),
      .empty_o (in_empty[p]),
      .full_o  (in_full[p])
    );

    assign xb_data[p] = in_head[xb_sel[p]];

    tsw_fifo #(.W(W), .DEPTH(FDEPTH)) u_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (xb_push[p]),
      .data_i  (xb_data[p]),
      .pop_i   (out_ready_i[p]),
      .data_o  (out_head[p]),
      .empty_o (out_empty[p]),
      .full_o  (out_full[p])
    );

    assign in_ready_o[p]         = ~in_full[p];
    assign out_valid_o[p]        = ~out_empty[p];
    assign out_data_o[p*W +: W]  = out_head[p];
  end
endmodule

// File: rtl/tsw_checker.sv
module tsw_checker #(
  parameter int NP = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NP-1:0] out_valid_i,
  input logic [NP-1:0] out_ready_i,
  input logic [NP-1:0] push_i,
  input logic [NP-1:0] pop_i,
  input logic [NP-1:0] in_empty_i,
  input logic [NP-1:0] out_full_i,
  input logic          running_i,
  input logic          err_i
);
  assert_pairs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(push_i) == $countones(pop_i));

  assert_dst_space_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i & out_full_i) == '0);

  assert_src_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i & in_empty_i) == '0);

  assert_skip_no_move_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> ($past(push_i) == '0));

  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_valid_i & ~out_ready_i) != '0) |=>
      ((out_valid_i & $past(out_valid_i & ~out_ready_i)) == $past(out_valid_i & ~out_ready_i)));

  assert_one_hop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i & ~$past(out_valid_i) & ~$past(push_i)) == '0);

  assert_idle_before_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_i |-> (push_i == '0 && pop_i == '0));
endmodule

bind tile_route_switch tsw_checker #(.NP(tsw_pkg::NPORT)) u_tsw_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .out_valid_i (out_valid_o),
  .out_ready_i (out_ready_i),
  .push_i      (xb_push),
  .pop_i       (xb_pop),
  .in_empty_i  (in_empty),
  .out_full_i  (out_full),
  .running_i   (seq_running),
  .err_i       (err_o)
);

// File: tb/tile_route_switch_test.sv
module tile_route_switch_test;
  localparam int W  = 32;
  localparam int AW = 4;
  localparam int NP = 5;
  localparam int IW = 16 + AW;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            prog_we;
  logic [AW-1:0]   prog_addr;
  logic [IW-1:0]   prog_data;
  logic [NP-1:0]   in_valid;
  logic [NP*W-1:0] in_data;
  logic [NP-1:0]   in_ready;
  logic [NP-1:0]   out_valid;
  logic [NP*W-1:0] out_data;
  logic [NP-1:0]   out_ready;
  logic            err;

  tile_route_switch #(.W(W), .AW(AW), .FDEPTH(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .prog_we_i(prog_we), .prog_addr_i(prog_addr),
    .prog_data_i(prog_data), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_ready_i(out_ready), .err_o(err)
  );

  always #2 clk = ~clk;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  // reference model state
  logic [W-1:0]  m_in  [NP][$];
  logic [W-1:0]  m_out [NP][$];
  logic [IW-1:0] m_mem [16];
  int            m_pc  = 0;
  bit            m_run = 0;
  bit            m_err = 0;

  task automatic chk(input bit good, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] mk(input int fn, input int fe, input int fs,
                                       input int fw, input int fp, input bit br, input int tgt);
    logic [IW-1:0] v;
    v = '0;
    v[2:0]   = 3'(fn);
    v[5:3]   = 3'(fe);
    v[8:6]   = 3'(fs);
    v[11:9]  = 3'(fw);
    v[14:12] = 3'(fp);
    v[15]    = br;
    v[19:16] = 4'(tgt);
    return v;
  endfunction

  always @(posedge clk) begin
    logic [IW-1:0] ins;
    bit            dup, bad, ok, fault, fire;
    bit [NP-1:0]   used, smask;
    int            src [NP];
    logic [W-1:0]  mv  [NP];
    int            code;
    fault = 0; fire = 0; used = '0; smask = '0;
    for (int k = 0; k < NP; k++) begin src[k] = 0; mv[k] = '0; end
    if (!rst_n) begin
      if (prog_we && !m_run) m_mem[prog_addr] = prog_data;
      for (int k = 0; k < NP; k++) begin m_in[k].delete(); m_out[k].delete(); end
      m_pc = 0; m_run = 0; m_err = 0;
    end else begin
      if (m_run) begin
        ins = m_mem[m_pc]; dup = 0; bad = 0; ok = 1;
        for (int k = 0; k < NP; k++) begin
          code = int'(ins[k*3 +: 3]);
          if (code != 0) begin
            used[k] = 1;
            if (code > 5) bad = 1;
            else begin
              src[k] = code - 1;
              if (smask[code-1]) dup = 1;
              smask[code-1] = 1;
              if (m_in[code-1].size() == 0 || m_out[k].size() >= 4) ok = 0;
            end
          end
        end
        fault = dup | bad;
        fire  = !fault && ok;
        if (fire)
          for (int k = 0; k < NP; k++) if (used[k]) mv[k] = m_in[src[k]][0];
      end
      if (prog_we && !m_run) m_mem[prog_addr] = prog_data;
      for (int k = 0; k < NP; k++)
        if (out_ready[k] && m_out[k].size() > 0) void'(m_out[k].pop_front());
      for (int k = 0; k < NP; k++)
        if (in_valid[k] && m_in[k].size() < 4) m_in[k].push_back(in_data[k*W +: W]);
      if (fire) begin
        for (int k = 0; k < NP; k++) if (smask[k]) void'(m_in[k].pop_front());
        for (int k = 0; k < NP; k++) if (used[k]) m_out[k].push_back(mv[k]);
      end
      if (fault || fire) m_pc = ins[15] ? int'(ins[19:16]) : (m_pc + 1) % 16;
      m_err = fault;
      m_run = 1;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      for (int k = 0; k < NP; k++) begin
        chk(in_ready[k] == (m_in[k].size() < 4), "R6", $sformatf("in_ready[%0d]", k),
            W'(in_ready[k]), W'(m_in[k].size() < 4));
        chk(out_valid[k] == (m_out[k].size() > 0), "R3 R4 R8", $sformatf("out_valid[%0d]", k),
            W'(out_valid[k]), W'(m_out[k].size() > 0));
        if (m_out[k].size() > 0)
          chk(out_data[k*W +: W] == m_out[k][0], "R1 R9", $sformatf("out_data[%0d]", k),
              out_data[k*W +: W], m_out[k][0]);
      end
      chk(err == m_err, "R5", "err_o", W'(err), W'(m_err));
    end
  end

  task automatic load_prog(input logic [IW-1:0] p [16]);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      prog_we = 1; prog_addr = 4'(a); prog_data = p[a];
    end
    @(negedge clk);
    prog_we = 0;
  endtask

  task automatic random_run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid  = NP'($urandom);
      out_ready = NP'($urandom);
      for (int k = 0; k < NP; k++) in_data[k*W +: W] = $urandom;
    end
    @(negedge clk);
    in_valid = '0; out_ready = '0;
  endtask

  initial begin
    #(4 * 30000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] prog [16];
    rst_n = 1; prog_we = 0; prog_addr = '0; prog_data = '0;
    in_valid = '0; in_data = '0; out_ready = '0;
    #1 rst_n = 0;

    // program 1: multi-route, chain, loop
    for (int a = 0; a < 16; a++) prog[a] = mk(0, 0, 0, 0, 0, 1, 0);
    prog[0] = mk(0, 0, 4, 0, 1, 0, 0);   // S<-W, P<-N
    prog[1] = mk(0, 5, 0, 0, 0, 0, 0);   // E<-P
    prog[2] = mk(2, 0, 0, 3, 0, 1, 0);   // N<-E, W<-S, back to 0
    load_prog(prog);
    chk(in_ready == 5'h1f, "R6", "reset in_ready", W'(in_ready), W'(5'h1f));
    chk(out_valid == 5'h00, "R3", "reset out_valid", W'(out_valid), 0);
    chk(err == 1'b0, "R5", "reset err_o", W'(err), 0);

    @(negedge clk);
    rst_n = 1;
    in_valid = 5'b01001;
    in_data[0*W +: W] = 32'h1111_0000;
    in_data[3*W +: W] = 32'h3333_0000;
    @(negedge clk);
    in_valid = '0;
    chk(out_valid[2] == 1'b0, "R7", "S valid one edge after accept", W'(out_valid[2]), 0);
    chk(out_valid[4] == 1'b0, "R7", "P valid one edge after accept", W'(out_valid[4]), 0);
    @(negedge clk);
    chk(out_valid[2] && out_valid[4], "R2", "S and P together", W'({out_valid[2], out_valid[4]}), 32'h3);
    chk(out_data[2*W +: W] == 32'h3333_0000, "R1", "S carries W word", out_data[2*W +: W], 32'h3333_0000);
    chk(out_data[4*W +: W] == 32'h1111_0000, "R1", "P carries N word", out_data[4*W +: W], 32'h1111_0000);
    random_run(3000);

    // program 2: faults, idle, loop; late write must be ignored
    @(negedge clk);
    rst_n = 0;
    for (int a = 0; a < 16; a++) prog[a] = mk(0, 0, 0, 0, 0, 1, 2);
    prog[0] = mk(0, 1, 1, 0, 0, 0, 0);   // two outputs from N
    prog[1] = mk(7, 0, 0, 0, 0, 0, 0);   // undefined code
    prog[2] = mk(0, 0, 0, 0, 0, 0, 0);   // idle
    prog[3] = mk(0, 0, 0, 5, 0, 1, 2);   // W<-P, back to 2
    load_prog(prog);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(err == 1'b0, "R8", "no issue on first edge", W'(err), 0);
    @(negedge clk);
    chk(err == 1'b1, "R5", "err after duplicate source", W'(err), 1);
    @(negedge clk);
    chk(err == 1'b1, "R5", "err after bad code", W'(err), 1);
    @(negedge clk);
    chk(err == 1'b0, "R4", "idle completes, no err", W'(err), 0);
    prog_we = 1; prog_addr = 4'd3; prog_data = mk(0, 0, 0, 1, 0, 1, 2);
    in_valid = 5'b10000; in_data[4*W +: W] = 32'h0000_abcd;
    @(negedge clk);
    prog_we = 0; in_valid = '0;
    repeat (3) @(negedge clk);
    chk(out_valid[3] == 1'b1, "R8", "late write ignored, W valid", W'(out_valid[3]), 1);
    chk(out_data[3*W +: W] == 32'h0000_abcd, "R8", "W carries P word", out_data[3*W +: W], 32'h0000_abcd);
    random_run(3000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule